// File: doc/BRIEF.md
# Configurable Asynchronous Serial Port with Line-Driver Enable

This block is a paired asynchronous serial transmitter and receiver. Bytes offered on a valid/ready input are framed and shifted out on `txd`. Frames arriving on `rxd` are assembled and delivered as single-cycle events that carry their parity, framing and break status. Every bit lasts 16 pulses of `baud_tick`, a one-cycle clock enable from an external baud generator. The frame format is chosen by static configuration inputs: 7 or 8 data bits, one of five parity modes, and one or two stop bits.

For half-duplex multi-drop transceivers, the transmitter drives `txden`. This output is high only while a character is on the line or a commanded break is held, and it is released once the final stop bit has run its full length. Optional hardware handshaking stops new characters from starting while the far end holds `cts_n` high. It also reports local receive room on `rts_n`. A break can be forced on the line, and an incoming break is recognised and reported apart from an ordinary framing error.

Top module: `uart485_core`

## Requirements
- R1: A transmitted frame is one low start bit, then the data bits LSB first (8 when `cfg_data8`=1, 7 otherwise), then the optional parity bit, then the stop bits. Each bit spans 16 `baud_tick` pulses counted from the cycle after acceptance. When 7 bits are received, `rx_data[7]` is 0.
- R2: `cfg_parity` encodes 0 = none, 1 = odd (data plus parity holds an odd count of ones), 2 = even, 3 = mark (always 1) and 4 = space (always 0). The codes 5 to 7 act as none.
- R3: The stop bits are high, one of them when `cfg_stop2`=0 and two when it is 1.
- R4: `txden` rises in the cycle after a character is accepted and stays high until the last stop bit's 16th tick. It falls with `txd` high. While idle it is low, and `tx_ready` is never high while `txden` is high.
- R5: With `cfg_flow_en`=1 and `cts_n`=1, `tx_ready` stays low and no character starts. `rts_n` equals `!rx_room` when `cfg_flow_en`=1 and is 0 otherwise.
- R6: While `tx_break` is high and no character is in flight, `txd` is held low, `txden` is held high and `tx_ready` is low. A character already in flight completes first. Lowering `tx_break` returns the line to idle high.
- R7: The receiver confirms a start bit 8 ticks after the falling edge is seen. A low pulse that is already high again at that point is discarded and produces no `rx_valid`.
- R8: Each received frame produces one single-cycle `rx_valid` pulse. The pulse carries `rx_data`, `rx_parity_err` (the received parity bit differs from the one computed under R2) and `rx_frame_err` (a stop bit was sampled low).
- R9: A frame in which every sampled bit, stop bits included, is low is reported with `rx_break`=1, `rx_data`=0 and both error flags 0. The receiver then waits for the line to go high before it looks for a new start bit.
- R10: During reset `txd` is 1, `txden` is 0 and `rx_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | Oversampling enable, 16 per bit |
| cfg_data8 | input | 1 | 1: 8 data bits, 0: 7 data bits |
| cfg_stop2 | input | 1 | 1: two stop bits |
| cfg_parity | input | 3 | Parity mode code (R2) |
| cfg_flow_en | input | 1 | Enable CTS gating and RTS output |
| tx_valid | input | 1 | Byte offered for transmission |
| tx_data | input | 8 | Byte to transmit |
| tx_ready | output | 1 | Byte accepted when high with tx_valid |
| tx_break | input | 1 | Hold a break on the line |
| txd | output | 1 | Serial output |
| txden | output | 1 | Line-driver enable |
| cts_n | input | 1 | Clear to send, active low |
| rts_n | output | 1 | Request to send, active low |
| rx_room | input | 1 | Receive side can accept data |
| rxd | input | 1 | Serial input |
| rx_valid | output | 1 | Received frame pulse |
| rx_data | output | 8 | Received byte |
| rx_parity_err | output | 1 | Parity mismatch for this frame |
| rx_frame_err | output | 1 | Low stop bit in this frame |
| rx_break | output | 1 | Frame was an all-low break |

## Verification
Several rules are checked by assertions on every cycle: `txden` falls only out of a stop or break state and with the line high, a character never starts against a deasserted CTS, a held break keeps the line low and the driver enabled, `rx_valid` lasts a single cycle, and a break report never carries error flags or data. Only the bench scenarios can show that the serial waveform matches each frame format bit by bit, and this is done by comparing against a tick-counting model on every clock. The same applies to the parity value for every mode, to a break that waits behind a character in flight, to glitch rejection, and to received bytes and their error flags.

// File: rtl/uart485_pkg.sv
`timescale 1ns/1ps
package uart485_pkg;

  localparam logic [2:0] PAR_NONE  = 3'd0;
  localparam logic [2:0] PAR_ODD   = 3'd1;
  localparam logic [2:0] PAR_EVEN  = 3'd2;
  localparam logic [2:0] PAR_MARK  = 3'd3;
  localparam logic [2:0] PAR_SPACE = 3'd4;

  typedef enum logic [2:0] {
    TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP, TX_BRK
  } tx_state_e;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_HOLD
  } rx_state_e;

  function automatic logic parity_on(input logic [2:0] mode);
    return (mode == PAR_ODD) || (mode == PAR_EVEN) ||
           (mode == PAR_MARK) || (mode == PAR_SPACE);
  endfunction

  // Parity bit value for an already masked data byte
  function automatic logic parity_val(input logic [7:0] d, input logic [2:0] mode);
    logic r;
    case (mode)
      PAR_ODD:  r = ~^d;
      PAR_EVEN: r = ^d;
      PAR_MARK: r = 1'b1;
      default:  r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/uart485_tx.sv
`timescale 1ns/1ps
module uart485_tx
  import uart485_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       cfg_data8,
  input  logic       cfg_stop2,
  input  logic [2:0] cfg_parity,
  input  logic       cfg_flow_en,
  input  logic       cts_n,
  input  logic       tx_valid,
  input  logic [7:0] tx_data,
  input  logic       tx_break,
  output logic       tx_ready,
  output logic       txd,
  output logic       txden
);

  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] SUB_LAST = CW'(OVS - 1);

  tx_state_e      st_q, st_d;
  logic [CW-1:0]  sub_q, sub_d;
  logic [2:0]     bit_q, bit_d;
  logic [7:0]     sh_q, sh_d;
  logic           par_q, par_d;
  logic           bit_end;
  logic           ready_c;
  logic [2:0]     last_idx;
  logic [7:0]     load_data;

  assign last_idx  = cfg_data8 ? 3'd7 : 3'd6;
  assign load_data = cfg_data8 ? tx_data : {1'b0, tx_data[6:0]};
  assign ready_c   = (st_q == TX_IDLE) && !tx_break && (!cfg_flow_en || !cts_n);
  assign bit_end   = tick && (sub_q == SUB_LAST);

  always_comb begin
    st_d  = st_q;
    sub_d = sub_q;
    bit_d = bit_q;
    sh_d  = sh_q;
    par_d = par_q;
    if (st_q != TX_IDLE && st_q != TX_BRK && tick)
      sub_d = bit_end ? '0 : sub_q + CW'(1);
    case (st_q)
      TX_IDLE: begin
        sub_d = '0;
        if (tx_break) begin
          st_d = TX_BRK;
        end else if (tx_valid && ready_c) begin
          st_d  = TX_START;
          sh_d  = load_data;
          par_d = parity_val(load_data, cfg_parity);
        end
      end
      TX_START: begin
        if (bit_end) begin
          st_d  = TX_DATA;
          bit_d = 3'd0;
        end
      end
      TX_DATA: begin
        if (bit_end) begin
          sh_d = {1'b0, sh_q[7:1]};
          if (bit_q == last_idx) begin
            st_d  = parity_on(cfg_parity) ? TX_PAR : TX_STOP;
            bit_d = 3'd0;
          end else begin
            bit_d = bit_q + 3'd1;
          end
        end
      end
      TX_PAR: begin
        if (bit_end) begin
          st_d  = TX_STOP;
          bit_d = 3'd0;
        end
      end
      TX_STOP: begin
        if (bit_end) begin
          if (cfg_stop2 && bit_q == 3'd0) bit_d = 3'd1;
          else                            st_d  = TX_IDLE;
        end
      end
      TX_BRK: begin
        sub_d = '0;
        if (!tx_break) st_d = TX_IDLE;
      end
      default: st_d = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= TX_IDLE;
      sub_q <= '0;
      bit_q <= '0;
      sh_q  <= '0;
      par_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      sub_q <= sub_d;
      bit_q <= bit_d;
      sh_q  <= sh_d;
      par_q <= par_d;
    end
  end

  always_comb begin
    case (st_q)
      TX_START: txd = 1'b0;
      TX_DATA:  txd = sh_q[0];
      TX_PAR:   txd = par_q;
      TX_BRK:   txd = 1'b0;
      default:  txd = 1'b1;
    endcase
  end

  assign txden    = (st_q != TX_IDLE);
  assign tx_ready = ready_c;

  // R4
  txden_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(txden) |-> (txd && ($past(st_q) == TX_STOP || $past(st_q) == TX_BRK)));

  // R4
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> !txden);

  // R5
  cts_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(txden) && st_q == TX_START) |-> (!cfg_flow_en || !$past(cts_n)));

  // R6
  break_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == TX_BRK && $past(st_q == TX_BRK)) |-> (txden && !txd && !tx_ready));

endmodule

// File: rtl/uart485_rx.sv
`timescale 1ns/1ps
module uart485_rx
  import uart485_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       cfg_data8,
  input  logic       cfg_stop2,
  input  logic [2:0] cfg_parity,
  input  logic       rxd,
  output logic       rx_valid,
  output logic [7:0] rx_data,
  output logic       rx_parity_err,
  output logic       rx_frame_err,
  output logic       rx_break
);

  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] SUB_LAST = CW'(OVS - 1);
  localparam logic [CW-1:0] SUB_MID  = CW'(OVS / 2 - 1);

  logic           sync1_q, rx_s;
  rx_state_e      st_q, st_d;
  logic [CW-1:0]  sub_q, sub_d;
  logic [2:0]     bit_q, bit_d;
  logic [7:0]     sh_q, sh_d;
  logic           zero_q, zero_d;
  logic           perr_q, perr_d;
  logic           ferr_q, ferr_d;
  logic           vld_q, vld_d;
  logic [7:0]     dat_q, dat_d;
  logic           pe_q, pe_d;
  logic           fe_q, fe_d;
  logic           bk_q, bk_d;
  logic           samp;
  logic           zero_now;
  logic           ferr_now;
  logic [2:0]     last_idx;
  logic [7:0]     asm_data;

  assign last_idx = cfg_data8 ? 3'd7 : 3'd6;
  assign asm_data = cfg_data8 ? sh_q : {1'b0, sh_q[7:1]};
  assign samp     = tick && (sub_q == SUB_LAST);
  assign zero_now = zero_q && !rx_s;
  assign ferr_now = ferr_q || !rx_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b1;
      rx_s    <= 1'b1;
    end else begin
      sync1_q <= rxd;
      rx_s    <= sync1_q;
    end
  end

  always_comb begin
    st_d   = st_q;
    sub_d  = sub_q;
    bit_d  = bit_q;
    sh_d   = sh_q;
    zero_d = zero_q;
    perr_d = perr_q;
    ferr_d = ferr_q;
    vld_d  = 1'b0;
    dat_d  = dat_q;
    pe_d   = pe_q;
    fe_d   = fe_q;
    bk_d   = bk_q;
    if ((st_q == RX_DATA || st_q == RX_PAR || st_q == RX_STOP) && tick)
      sub_d = samp ? '0 : sub_q + CW'(1);
    case (st_q)
      RX_IDLE: begin
        if (tick && !rx_s) begin
          st_d  = RX_START;
          sub_d = '0;
        end
      end
      RX_START: begin
        if (tick) begin
          if (sub_q == SUB_MID) begin
            sub_d = '0;
            if (rx_s) begin
              st_d = RX_IDLE;
            end else begin
              st_d   = RX_DATA;
              bit_d  = 3'd0;
              zero_d = 1'b1;
              perr_d = 1'b0;
              ferr_d = 1'b0;
            end
          end else begin
            sub_d = sub_q + CW'(1);
          end
        end
      end
      RX_DATA: begin
        if (samp) begin
          sh_d   = {rx_s, sh_q[7:1]};
          zero_d = zero_now;
          if (bit_q == last_idx) begin
            st_d  = parity_on(cfg_parity) ? RX_PAR : RX_STOP;
            bit_d = 3'd0;
          end else begin
            bit_d = bit_q + 3'd1;
          end
        end
      end
      RX_PAR: begin
        if (samp) begin
          perr_d = (rx_s != parity_val(asm_data, cfg_parity));
          zero_d = zero_now;
          st_d   = RX_STOP;
        end
      end
      RX_STOP: begin
        if (samp) begin
          if (cfg_stop2 && bit_q == 3'd0) begin
            bit_d  = 3'd1;
            zero_d = zero_now;
            ferr_d = ferr_now;
          end else begin
            vld_d = 1'b1;
            bk_d  = zero_now;
            dat_d = zero_now ? 8'h00 : asm_data;
            pe_d  = zero_now ? 1'b0 : perr_q;
            fe_d  = zero_now ? 1'b0 : ferr_now;
            st_d  = rx_s ? RX_IDLE : RX_HOLD;
          end
        end
      end
      RX_HOLD: begin
        if (rx_s) st_d = RX_IDLE;
      end
      default: st_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RX_IDLE;
      sub_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      zero_q <= 1'b0;
      perr_q <= 1'b0;
      ferr_q <= 1'b0;
      vld_q  <= 1'b0;
      dat_q  <= '0;
      pe_q   <= 1'b0;
      fe_q   <= 1'b0;
      bk_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      sub_q  <= sub_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
      zero_q <= zero_d;
      perr_q <= perr_d;
      ferr_q <= ferr_d;
      vld_q  <= vld_d;
      dat_q  <= dat_d;
      pe_q   <= pe_d;
      fe_q   <= fe_d;
      bk_q   <= bk_d;
    end
  end

  assign rx_valid      = vld_q;
  assign rx_data       = dat_q;
  assign rx_parity_err = pe_q;
  assign rx_frame_err  = fe_q;
  assign rx_break      = bk_q;

  // R8
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R9
  break_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_break) |-> (!rx_frame_err && !rx_parity_err && rx_data == 8'h00));

  // R1
  data7_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !cfg_data8) |-> !rx_data[7]);

  // R7
  glitch_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == RX_START && tick && sub_q == SUB_MID && rx_s) |=> (st_q == RX_IDLE));

endmodule

// File: rtl/uart485_core.sv
`timescale 1ns/1ps
module uart485_core #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic       cfg_data8,
  input  logic       cfg_stop2,
  input  logic [2:0] cfg_parity,
  input  logic       cfg_flow_en,
  input  logic       tx_valid,
  input  logic [7:0] tx_data,
  output logic       tx_ready,
  input  logic       tx_break,
  output logic       txd,
  output logic       txden,
  input  logic       cts_n,
  output logic       rts_n,
  input  logic       rx_room,
  input  logic       rxd,
  output logic       rx_valid,
  output logic [7:0] rx_data,
  output logic       rx_parity_err,
  output logic       rx_frame_err,
  output logic       rx_break
);

  uart485_tx #(.OVS(OVS)) u_tx (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (baud_tick),
    .cfg_data8   (cfg_data8),
    .cfg_stop2   (cfg_stop2),
    .cfg_parity  (cfg_parity),
    .cfg_flow_en (cfg_flow_en),
    .cts_n       (cts_n),
    .tx_valid    (tx_valid),
    .tx_data     (tx_data),
    .tx_break    (tx_break),
    .tx_ready    (tx_ready),
    .txd         (txd),
    .txden       (txden)
  );

  uart485_rx #(.OVS(OVS)) u_rx (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick          (baud_tick),
    .cfg_data8     (cfg_data8),
    .cfg_stop2     (cfg_stop2),
    .cfg_parity    (cfg_parity),
    .rxd           (rxd),
    .rx_valid      (rx_valid),
    .rx_data       (rx_data),
    .rx_parity_err (rx_parity_err),
    .rx_frame_err  (rx_frame_err),
    .rx_break      (rx_break)
  );

  assign rts_n = cfg_flow_en ? !rx_room : 1'b0;

endmodule

// File: tb/tb_uart485_core.sv
`timescale 1ns/1ps
module tb_uart485_core;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       baud_tick;
  logic       cfg_data8, cfg_stop2, cfg_flow_en;
  logic [2:0] cfg_parity;
  logic       tx_valid, tx_break, cts_n, rx_room, rxd;
  logic [7:0] tx_data;
  logic       tx_ready, txd, txden, rts_n;
  logic       rx_valid, rx_parity_err, rx_frame_err, rx_break;
  logic [7:0] rx_data;

  always #2 clk = ~clk;

  uart485_core dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
    .cfg_data8(cfg_data8), .cfg_stop2(cfg_stop2), .cfg_parity(cfg_parity),
    .cfg_flow_en(cfg_flow_en), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .tx_break(tx_break), .txd(txd), .txden(txden),
    .cts_n(cts_n), .rts_n(rts_n), .rx_room(rx_room), .rxd(rxd),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_parity_err(rx_parity_err),
    .rx_frame_err(rx_frame_err), .rx_break(rx_break)
  );

  int    vecs = 0;
  int    errs = 0;
  bit    done = 1'b0;
  string cur_req = "R10";

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vecs++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s got %0h exp %0h", tag, got, exp);
    end
  endtask

  // baud enable: one pulse every 4 clocks, so a bit lasts 64 clocks
  logic [1:0] tdiv;
  always @(posedge clk or negedge rst_n)
    if (!rst_n) tdiv <= 2'd0;
    else        tdiv <= tdiv + 2'd1;
  assign baud_tick = (tdiv == 2'd3);

  function automatic bit par_of(input logic [7:0] d, input bit d8, input logic [2:0] m);
    int ones = 0;
    for (int i = 0; i < 8; i++) if ((d8 || i < 7) && d[i]) ones++;
    case (m)
      3'd1: return (ones % 2) == 0;
      3'd2: return (ones % 2) == 1;
      3'd3: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit par_en(input logic [2:0] m);
    return (m >= 3'd1) && (m <= 3'd4);
  endfunction

  // ---------------- transmit reference model ----------------
  bit m_q[$];
  int m_cnt;
  bit m_brk;

  function automatic bit exp_ready();
    return (m_q.size() == 0) && !m_brk && !tx_break && (!cfg_flow_en || !cts_n);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q.delete();
      m_cnt = 0;
      m_brk = 1'b0;
    end else if (m_q.size() != 0) begin
      if (baud_tick) begin
        if (m_cnt == 15) begin
          void'(m_q.pop_front());
          m_cnt = 0;
        end else m_cnt++;
      end
    end else if (m_brk) begin
      if (!tx_break) m_brk = 1'b0;
    end else if (tx_break) begin
      m_brk = 1'b1;
    end else if (tx_valid && exp_ready()) begin
      m_cnt = 0;
      m_q.push_back(1'b0);
      for (int i = 0; i < (cfg_data8 ? 8 : 7); i++) m_q.push_back(tx_data[i]);
      if (par_en(cfg_parity)) m_q.push_back(par_of(tx_data, cfg_data8, cfg_parity));
      m_q.push_back(1'b1);
      if (cfg_stop2) m_q.push_back(1'b1);
    end
  end

  // ---------------- receive expectations ----------------
  logic [10:0] rx_exp[$];
  string       rx_tag[$];

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check({cur_req, " txd"},   txd,   (m_q.size() != 0) ? m_q[0] : !m_brk);
      check({cur_req, " txden"}, txden, (m_q.size() != 0) || m_brk);
      check({cur_req, " tx_ready"}, tx_ready, exp_ready());
      // R5 rts mirrors receive room when handshaking is on
      check("R5 rts_n", rts_n, cfg_flow_en ? !rx_room : 1'b0);
      if (rx_valid) begin
        if (rx_exp.size() == 0) begin
          check("R7 R8 unexpected rx_valid", 1, 0);
        end else begin
          check(rx_tag.pop_front(), {rx_break, rx_frame_err, rx_parity_err, rx_data},
                rx_exp.pop_front());
        end
      end
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic set_cfg(input bit d8, input bit s2, input logic [2:0] p);
    @(negedge clk); #1;
    cfg_data8 = d8; cfg_stop2 = s2; cfg_parity = p;
  endtask

  task automatic wait_accept();
    forever begin
      @(negedge clk);
      if (tx_ready) begin
        @(posedge clk); #1;
        tx_valid = 1'b0;
        break;
      end
    end
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (txden);
    repeat (8) @(negedge clk);
  endtask

  task automatic send_tx(input logic [7:0] d);
    @(negedge clk); #1;
    tx_valid = 1'b1; tx_data = d;
    wait_accept();
    wait_idle();
  endtask

  task automatic rx_bit(input bit b);
    rxd = b;
    repeat (64) @(negedge clk);
  endtask

  task automatic send_rx(input string tag, input logic [7:0] d, input bit bad_par, input bit bad_stop);
    logic [7:0] dm;
    bit p;
    dm = cfg_data8 ? d : {1'b0, d[6:0]};
    p  = par_of(dm, cfg_data8, cfg_parity);
    rx_exp.push_back({1'b0, bad_stop, bad_par && par_en(cfg_parity), dm});
    rx_tag.push_back(tag);
    @(negedge clk); #1;
    rx_bit(1'b0);
    for (int i = 0; i < (cfg_data8 ? 8 : 7); i++) rx_bit(dm[i]);
    if (par_en(cfg_parity)) rx_bit(p ^ bad_par);
    if (cfg_stop2) rx_bit(1'b1);
    rx_bit(!bad_stop);
    rx_bit(1'b1);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errs++;
      $display("FAIL watchdog expired got 1 exp 0");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    rst_n = 1'b0;
    cfg_data8 = 1'b1; cfg_stop2 = 1'b0; cfg_parity = 3'd0; cfg_flow_en = 1'b0;
    tx_valid = 1'b0; tx_data = 8'h00; tx_break = 1'b0;
    cts_n = 1'b0; rx_room = 1'b1; rxd = 1'b1;
    repeat (4) @(negedge clk);
    // R10 reset values
    check("R10 txd in reset", txd, 1);
    check("R10 txden in reset", txden, 0);
    check("R10 rx_valid in reset", rx_valid, 0);
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 R3 R4: 8 data bits, no parity, one stop
    cur_req = "R1 R3 R4";
    send_tx(8'hA5);
    send_tx(8'h3C);
    // R2 R3: every parity code and both stop counts
    cur_req = "R2 R3";
    set_cfg(1'b0, 1'b0, 3'd2); send_tx(8'hDA);
    set_cfg(1'b1, 1'b1, 3'd1); send_tx(8'h81);
    set_cfg(1'b0, 1'b1, 3'd3); send_tx(8'h00);
    set_cfg(1'b1, 1'b0, 3'd4); send_tx(8'hFF);
    set_cfg(1'b1, 1'b0, 3'd7); send_tx(8'h96);
    set_cfg(1'b1, 1'b1, 3'd2); send_tx(8'h07);

    // R5 CTS gating
    cur_req = "R5";
    set_cfg(1'b1, 1'b0, 3'd0);
    #1 cfg_flow_en = 1'b1; cts_n = 1'b1; tx_valid = 1'b1; tx_data = 8'h5E;
    repeat (300) @(negedge clk);
    check("R5 no start while CTS high", txden, 0);
    #1 rx_room = 1'b0;
    @(negedge clk);
    check("R5 rts_n follows room", rts_n, 1);
    #1 cts_n = 1'b0;
    wait_accept();
    wait_idle();
    #1 cfg_flow_en = 1'b0; rx_room = 1'b1;

    // R6 break from idle
    cur_req = "R6";
    @(negedge clk); #1 tx_break = 1'b1;
    repeat (400) @(negedge clk);
    check("R6 break line low", txd, 0);
    check("R6 break driver on", txden, 1);
    #1 tx_break = 1'b0;
    repeat (20) @(negedge clk);
    check("R6 line idle after break", txd, 1);
    // R6 break requested while a character is in flight
    @(negedge clk); #1 tx_valid = 1'b1; tx_data = 8'hC3;
    wait_accept();
    repeat (100) @(negedge clk);
    #1 tx_break = 1'b1;
    repeat (1200) @(negedge clk);
    check("R6 break after character", txd, 0);
    #1 tx_break = 1'b0;
    repeat (20) @(negedge clk);

    // R8 receive with various formats
    cur_req = "R8";
    set_cfg(1'b1, 1'b0, 3'd0); send_rx("R8 rx 8N1", 8'h5A, 1'b0, 1'b0);
    set_cfg(1'b0, 1'b0, 3'd2); send_rx("R1 R2 rx 7E1", 8'hF3, 1'b0, 1'b0);
    set_cfg(1'b1, 1'b1, 3'd1); send_rx("R2 rx 8O2", 8'h81, 1'b0, 1'b0);
    set_cfg(1'b1, 1'b0, 3'd1); send_rx("R8 rx parity error", 8'h44, 1'b1, 1'b0);
    set_cfg(1'b1, 1'b0, 3'd3); send_rx("R2 rx mark", 8'h12, 1'b0, 1'b0);
    set_cfg(1'b1, 1'b0, 3'd4); send_rx("R2 rx space bad", 8'h12, 1'b1, 1'b0);
    set_cfg(1'b1, 1'b0, 3'd0); send_rx("R8 rx frame error", 8'h55, 1'b0, 1'b1);
    set_cfg(1'b1, 1'b1, 3'd2); send_rx("R3 rx stop2 frame error", 8'h6B, 1'b0, 1'b1);

    // R7 short low pulse is dropped
    set_cfg(1'b1, 1'b0, 3'd0);
    @(negedge clk); #1 rxd = 1'b0;
    repeat (12) @(negedge clk);
    #1 rxd = 1'b1;
    repeat (900) @(negedge clk);
    check("R7 glitch produced nothing", rx_exp.size(), 0);
    send_rx("R7 frame after glitch", 8'hE1, 1'b0, 1'b0);

    // R9 incoming break, then a normal frame
    set_cfg(1'b0, 1'b1, 3'd2);
    rx_exp.push_back({1'b1, 1'b0, 1'b0, 8'h00});
    rx_tag.push_back("R9 rx break");
    @(negedge clk); #1 rxd = 1'b0;
    repeat (64 * 16) @(negedge clk);
    #1 rxd = 1'b1;
    repeat (128) @(negedge clk);
    send_rx("R9 frame after break", 8'h2D, 1'b0, 1'b0);

    repeat (50) @(negedge clk);
    check("R8 all expected frames seen", rx_exp.size(), 0);

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

endmodule